// File: doc/BRIEF.md
# Host ADC Frame Controller

This block is the host-side master for a two-channel, 12-bit serial converter that uses a 16-clock conversion frame. A client places a request on a valid/ready handshake. The request carries a channel number, two power-mode bits, three option bits, a wake-up flag and a read-only flag. The controller then does the following for one frame:

- It pulls chip select low.
- If the wake-up flag is set, it waits a fixed number of system clocks so the converter can leave power-down.
- It generates sixteen serial clock periods from a system-clock divider.
- It shifts an 8-bit control word out on its data output, most significant bit first.
- It collects sixteen bits from the converter on rising serial clock edges.

When the frame ends, chip select goes high. In that same cycle the block presents the 12-bit result, a flag that is set when any of the four leading bits was not zero, and the channel the result belongs to.

The converter samples the channel that was programmed in the previous frame. For this reason the controller keeps track of which channel each frame writes, and labels every result with the channel written one frame earlier. A read-only frame writes an all-zero control word, so it programs channel 0. The first result after reset has no earlier programming, and its label is marked as not valid.

Top module: `adc_frame_ctrl`

## Requirements
- R1: Chip select (`adc_cs_n`, active low) stays low for exactly sixteen serial clock periods per frame. `adc_sclk` idles high and toggles only while chip select is low. The first edge after chip select falls is a falling edge, and the frame contains 16 falling edges and 16 rising edges.
- R2: Each serial clock half period lasts `SCLK_HALF` system clocks. Without wake-up, the first falling edge comes `SCLK_HALF` system clocks after chip select falls.
- R3: With `req_wake` set, the first falling edge comes `WAKE_CYCLES + SCLK_HALF` system clocks after chip select falls.
- R4: The control word is {opt[2:0], chan, 2'b00, mode[1:0]}, with bit 7 on the left. It is shifted out MSB first on `adc_din`. `adc_din` changes only on serial clock falling edges, or when chip select switches, so bit 7-k is valid on rising edge k+1 for the first eight rising edges.
- R5: With `req_rdonly` set, `adc_din` stays low for the whole frame.
- R6: `adc_dout` is sampled on each of the 16 rising edges, and `res_data` holds the last twelve bits sampled, MSB first.
- R7: `res_err` is 1 exactly when any of the first four bits sampled is 1.
- R8: `res_chan` is the channel programmed by the previous frame. That is `req_chan` of that frame, or 0 if that frame was read-only.
- R9: The first result after reset has `res_chan_ok` = 0. Every later result has `res_chan_ok` = 1.
- R10: `req_ready` is high only when the block is idle, and `busy` is high whenever chip select is low. `res_valid` is a one-cycle pulse in the cycle in which chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_chan | input | 1 | Channel to program for the next conversion |
| req_mode | input | 2 | Power-mode bits of the control word |
| req_opt | input | 3 | Option bits of the control word |
| req_wake | input | 1 | Insert the wake-up wait after chip select falls |
| req_rdonly | input | 1 | Read-only frame: hold the data line low |
| busy | output | 1 | A frame is in progress |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_din | output | 1 | Control word to the converter |
| adc_dout | input | 1 | Conversion data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Conversion result |
| res_err | output | 1 | A leading bit was not zero |
| res_chan | output | 1 | Channel the result belongs to |
| res_chan_ok | output | 1 | `res_chan` is meaningful |

## Verification
A table of frames mixes the two channels, read-only frames, wake-up frames, a corrupted leading bit, and data words such as all ones and alternating patterns. Each of these shows a separate property:
- Alternating channels, with read-only frames placed between them, show that the label follows the previous frame and that read-only frames program channel 0.
- An all-ones result next to zero leading bits shows that the block strips the correct four bits.
- A wake-up frame next to a normal frame shows that the extra delay applies only when it was requested.

A reset in the middle of a frame checks that the bus returns to idle and that the first result afterwards is marked as not labelled.

// File: rtl/adc_frame_pkg.sv
// Package: shared constants, state type and control-word packing for the
// host ADC frame controller. Assumes a 16-bit frame with an 8-bit command.
package adc_frame_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int LEAD_BITS  = 4;
    localparam int RES_BITS   = FRAME_BITS - LEAD_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAKE  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_END   = 2'd3
    } frame_st_t;

    // Build the command byte: {opt[2:0], chan, 2'b00, mode[1:0]}.
    function automatic logic [CMD_BITS-1:0] pack_cmd(
        input logic [2:0] opt,
        input logic       chan,
        input logic [1:0] mode
    );
        return {opt, chan, 2'b00, mode};
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
// Module: half-period tick generator for the serial clock.
// Assumes HALF >= 1; the counter is held clear while run is low so every
// frame begins with a full half period.
module adc_sclk_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    // Count system clocks within one serial-clock half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the half-period counter never passes its limit.
    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < HALF));

endmodule

// File: rtl/adc_rx_shift.sv
// Module: collects the 16 frame bits from the converter and splits them
// into the four leading bits and the 12-bit result. Assumes sample pulses
// arrive once per rising serial clock edge.
module adc_rx_shift
    import adc_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic                bit_in,
    output logic [RES_BITS-1:0] result,
    output logic                lead_err
);
    logic [FRAME_BITS-1:0] sr;

    // Shift in one converter bit per rising serial clock edge, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr <= '0;
        end else if (sample) begin
            sr <= {sr[FRAME_BITS-2:0], bit_in};
        end
    end

    assign result   = sr[RES_BITS-1:0];
    assign lead_err = |sr[FRAME_BITS-1:RES_BITS];

endmodule

// File: rtl/adc_chan_tracker.sv
// Module: labels each result with the channel programmed one frame earlier.
// Assumes frame_done pulses once per completed frame; wr_chan is the
// channel that frame wrote into the converter.
module adc_chan_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic wr_chan,
    output logic res_chan,
    output logic res_chan_ok
);
    logic prog_chan;
    logic prog_ok;

    // Move the programmed channel to the output and store the new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_chan   <= 1'b0;
            prog_ok     <= 1'b0;
            res_chan    <= 1'b0;
            res_chan_ok <= 1'b0;
        end else if (frame_done) begin
            res_chan    <= prog_chan;
            res_chan_ok <= prog_ok;
            prog_chan   <= wr_chan;
            prog_ok     <= 1'b1;
        end
    end

    // R8: after a frame the programmed channel is the one just written.
    p_prog_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (prog_chan == $past(wr_chan)) && prog_ok);

    // R9: a result label is valid only once some frame has programmed it.
    p_first_untagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !prog_ok) |=> !res_chan_ok);

endmodule

// File: rtl/adc_frame_ctrl.sv
// Module: top of the host ADC frame controller. Accepts one request per
// frame, drives chip select, serial clock and command data, and returns a
// labelled 12-bit result. Assumes the converter updates its data output on
// falling serial clock edges and WAKE_CYCLES >= 1.
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int SCLK_HALF   = 2,
    parameter int WAKE_CYCLES = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_chan,
    input  logic [1:0]          req_mode,
    input  logic [2:0]          req_opt,
    input  logic                req_wake,
    input  logic                req_rdonly,
    output logic                busy,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                adc_din,
    input  logic                adc_dout,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_err,
    output logic                res_chan,
    output logic                res_chan_ok
);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    frame_st_t             st;
    logic [BW-1:0]         bit_cnt;
    logic [WW-1:0]         wake_cnt;
    logic [CMD_BITS-1:0]   cmd_q;
    logic                  chan_q;
    logic                  rdonly_q;
    logic                  tick;
    logic                  accept;
    logic                  rx_sample;
    logic                  frame_done;
    logic                  din_nx;
    logic [2:0]            din_idx;
    logic [RES_BITS-1:0]   rx_result;
    logic                  rx_lead;

    assign req_ready  = (st == ST_IDLE);
    assign busy       = (st != ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign rx_sample  = (st == ST_SHIFT) && tick && !adc_sclk;
    assign frame_done = (st == ST_END) && tick;

    // Pick the command bit that goes out on the coming falling edge.
    always_comb begin
        din_idx = 3'(CMD_BITS - 1) - bit_cnt[2:0];
        din_nx  = (int'(bit_cnt) < CMD_BITS) ? cmd_q[din_idx] : 1'b0;
    end

    adc_sclk_div #(.HALF(SCLK_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((st == ST_SHIFT) || (st == ST_END)),
        .tick (tick)
    );

    adc_rx_shift u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (rx_sample),
        .bit_in  (adc_dout),
        .result  (rx_result),
        .lead_err(rx_lead)
    );

    adc_chan_tracker u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .wr_chan    (chan_q),
        .res_chan   (res_chan),
        .res_chan_ok(res_chan_ok)
    );

    // Frame sequencer: chip select, wake wait, serial clock and data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            adc_cs_n  <= 1'b1;
            adc_sclk  <= 1'b1;
            adc_din   <= 1'b0;
            bit_cnt   <= '0;
            wake_cnt  <= '0;
            cmd_q     <= '0;
            chan_q    <= 1'b0;
            rdonly_q  <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        adc_cs_n <= 1'b0;
                        adc_din  <= 1'b0;
                        bit_cnt  <= '0;
                        wake_cnt <= '0;
                        rdonly_q <= req_rdonly;
                        chan_q   <= req_rdonly ? 1'b0 : req_chan;
                        cmd_q    <= req_rdonly ? '0
                                              : pack_cmd(req_opt, req_chan, req_mode);
                        st       <= req_wake ? ST_WAKE : ST_SHIFT;
                    end
                end
                ST_WAKE: begin
                    if (int'(wake_cnt) == WAKE_CYCLES - 1) begin
                        st <= ST_SHIFT;
                    end else begin
                        wake_cnt <= wake_cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (adc_sclk) begin
                            adc_sclk <= 1'b0;
                            adc_din  <= din_nx;
                        end else begin
                            adc_sclk <= 1'b1;
                            bit_cnt  <= bit_cnt + 1'b1;
                            if (int'(bit_cnt) == FRAME_BITS - 1) begin
                                st <= ST_END;
                            end
                        end
                    end
                end
                ST_END: begin
                    if (tick) begin
                        adc_cs_n  <= 1'b1;
                        adc_din   <= 1'b0;
                        res_valid <= 1'b1;
                        res_data  <= rx_result;
                        res_err   <= rx_lead;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: the serial clock is low only inside a frame.
    p_sclk_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_sclk |-> !adc_cs_n);

    // R1: never more than sixteen rising edges per frame.
    p_bit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= FRAME_BITS);

    // R4: the data line moves only on a falling edge or a chip-select change.
    p_din_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_din) |-> ($fell(adc_sclk) || $fell(adc_cs_n) || $rose(adc_cs_n)));

    // R5: a read-only frame keeps the data line low.
    p_rdonly_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && rdonly_q) |-> !adc_din);

    // R10: result strobe coincides with chip select returning high.
    p_valid_at_cs_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));

    // R10: result strobe lasts a single cycle.
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10: busy covers the whole time chip select is low.
    p_busy_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy);

endmodule

// File: tb/adc_frame_ctrl_tb.sv
// Bench: runs a table of frames against a converter model, then directed
// reset and corner tests. Reports through its own counters.
module adc_frame_ctrl_tb;
    localparam int HALF = 2;
    localparam int WAKE = 10;
    localparam int NV   = 7;

    // Fields: [20] wake, [19] rdonly, [18] chan, [17:16] mode,
    //         [15:13] opt, [12] bad leading bit, [11:0] converter value
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 2'b01, 3'b101, 1'b0, 12'hA5C},
        {1'b1, 1'b0, 1'b0, 2'b10, 3'b010, 1'b0, 12'hFFF},
        {1'b0, 1'b1, 1'b1, 2'b11, 3'b111, 1'b0, 12'h001},
        {1'b0, 1'b0, 1'b1, 2'b00, 3'b100, 1'b1, 12'h555},
        {1'b1, 1'b1, 1'b0, 2'b01, 3'b011, 1'b0, 12'h800},
        {1'b0, 1'b0, 1'b1, 2'b11, 3'b001, 1'b0, 12'h3C3},
        {1'b0, 1'b0, 1'b0, 2'b10, 3'b110, 1'b0, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_chan = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [2:0]  req_opt = '0;
    logic        req_wake = 1'b0;
    logic        req_rdonly = 1'b0;
    logic        adc_dout = 1'b0;
    logic        req_ready, busy, adc_cs_n, adc_sclk, adc_din;
    logic        res_valid, res_err, res_chan, res_chan_ok;
    logic [11:0] res_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Converter model state
    logic [11:0] m_val = '0;
    bit          m_bad = 0;
    logic [15:0] m_frame = '0;
    logic [7:0]  cap_word = '0;
    int n_out = 0, n_in = 0, falls = 0, rises = 0, setup_cnt = 0;
    bit seen_fall = 0, din_high = 0;

    // Expected label tracking
    bit   prev_ok = 0;
    logic prev_chan = 1'b0;

    always #10 clk = ~clk;

    adc_frame_ctrl #(.SCLK_HALF(HALF), .WAKE_CYCLES(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_mode(req_mode), .req_opt(req_opt),
        .req_wake(req_wake), .req_rdonly(req_rdonly), .busy(busy),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_dout(adc_dout), .res_valid(res_valid), .res_data(res_data),
        .res_err(res_err), .res_chan(res_chan), .res_chan_ok(res_chan_ok)
    );

    // Model: start of frame loads the 16 bits it will send.
    always @(negedge adc_cs_n) begin
        n_out = 0; n_in = 0; falls = 0; rises = 0; setup_cnt = 0;
        seen_fall = 0; din_high = 0; cap_word = '0;
        m_frame = m_bad ? {4'b0010, m_val} : {4'b0000, m_val};
    end

    // Model: each falling edge presents the next bit.
    always @(negedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            if (n_out < 16) adc_dout <= m_frame[15 - n_out];
            n_out++;
            falls++;
            seen_fall = 1;
        end
    end

    // Model: rising edges take in the command byte.
    always @(posedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            rises++;
            if (n_in < 8) begin
                cap_word = {cap_word[6:0], adc_din};
                n_in++;
            end
        end
    end

    // Measure time from chip select fall to first falling edge, and watch DIN.
    always @(negedge clk) begin
        if (adc_cs_n === 1'b0) begin
            if (!seen_fall && adc_sclk === 1'b1) setup_cnt++;
            if (adc_din === 1'b1) din_high = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [20:0] v);
        bit got;
        logic [7:0] exp_word;
        got = 0;
        m_val = v[11:0];
        m_bad = v[12];
        exp_word = v[19] ? 8'h00 : {v[15:13], v[18], 2'b00, v[17:16]};
        @(negedge clk);
        req_wake = v[20]; req_rdonly = v[19]; req_chan = v[18];
        req_mode = v[17:16]; req_opt = v[15:13]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && busy && !adc_cs_n, "R10", "ready/busy in frame",
            {req_ready, busy, adc_cs_n}, 3'b010);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (res_valid) begin got = 1; break; end
        end
        chk(got && adc_cs_n, "R10", "strobe with cs high", {got, adc_cs_n}, 2'b11);
        chk(falls == 16 && rises == 16, "R1", "edge count", falls * 100 + rises, 1616);
        chk(setup_cnt == (v[20] ? WAKE + HALF : HALF), v[20] ? "R3" : "R2",
            "clocks to first fall", setup_cnt, v[20] ? WAKE + HALF : HALF);
        chk(cap_word == exp_word, "R4", "command word", cap_word, exp_word);
        if (v[19]) chk(!din_high, "R5", "din high in read-only", din_high, 0);
        chk(res_data == v[11:0], "R6", "result", res_data, v[11:0]);
        chk(res_err == v[12], "R7", "lead error", res_err, v[12]);
        chk(res_chan_ok == prev_ok, "R9", "label valid", res_chan_ok, prev_ok);
        if (prev_ok) chk(res_chan == prev_chan, "R8", "label", res_chan, prev_chan);
        prev_ok = 1;
        prev_chan = v[19] ? 1'b0 : v[18];
        @(negedge clk);
        chk(!res_valid && req_ready, "R10", "strobe one cycle", {res_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n && adc_sclk && !adc_din, "R1", "idle bus after reset",
            {adc_cs_n, adc_sclk, adc_din}, 3'b110);
        chk(req_ready && !busy && !res_valid, "R10", "idle handshake after reset",
            {req_ready, busy, res_valid}, 3'b100);

        for (int k = 0; k < NV; k++) run_frame(VEC[k]);

        // Reset in the middle of a frame.
        @(negedge clk);
        req_chan = 1'b1; req_rdonly = 1'b0; req_wake = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n && adc_sclk && req_ready, "R1", "bus idle after mid-frame reset",
            {adc_cs_n, adc_sclk, req_ready}, 3'b111);
        prev_ok = 0;
        run_frame({1'b0, 1'b0, 1'b1, 2'b00, 3'b000, 1'b0, 12'h7E1});
        run_frame({1'b1, 1'b0, 1'b0, 2'b11, 3'b111, 1'b0, 12'h18F});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule